// File: doc/BRIEF.md
# Staggered Sinc2 Decimation Filter

This block turns the one-bit output of a first-order sigma-delta modulator into multi-bit samples using a second-order sinc response. A first integrator counts the ones in the bitstream and is shared by all phases. Several phases each keep a second integrator and a differentiator register. The second integrator is cleared at every period boundary (integrate-and-dump), so one differentiator stage per phase is enough.

The phases run at evenly spaced time offsets within the decimation period. As a result, overlapping samples leave the block several times per period instead of once. A configuration picks the period length and the number of phases. The number of phases is limited so that the active register bits never exceed a fixed budget.

The output is a zero-extended word with a one-cycle valid strobe. The stream has no back-pressure: the modulator cannot be paused, so the consumer must accept every sample in the cycle its strobe is high.

Top module: `sinc2_stagger_dec`

## Requirements
- R1: On a period boundary at clock edge e, the emitted sample equals the sum over m = 0 … 2N−2 of min(m+1, 2N−1−m)·b(e−m), taken modulo 2^W and zero-extended to 16 bits. Here b(x) is the modulator bit captured at edge x, and bits at or before a reset edge count as zero. An all-ones input therefore wraps to 0.
- R2: The `len_sel` codes 0 to 4 select N = 16·2^code clocks and a register width W = 8 + 2·code. Codes 5 to 7 behave as code 4.
- R3: The effective phase count P is `ph_sel` clamped to the range 1 … Pmax. Pmax is 6, 5, 4, 3 and 3 for N = 16, 32, 64, 128 and 256, which keeps W·(1+2P) within 112 bits.
- R4: Let r be the last restart edge. Phase k (0 ≤ k < P) closes a period on every edge e > r where (e−r−1) mod N = (⌊k·N/P⌋ − 1) mod N. `sample_valid` is a one-cycle pulse per emitted sample and is never high on two consecutive cycles.
- R5: A boundary of a phase raises `sample_valid` only if that phase has already had at least two boundaries since the last restart.
- R6: Any edge at which `len_sel` or `ph_sel` differ from the captured values is a restart edge. At that edge the new setting is adopted, every second integrator and differentiator is cleared, and `sample_valid` is low after it. The first integrator keeps counting and includes the bit at that edge.
- R7: Reset is synchronous and active low. Every edge with `rst_n` low is a restart edge that also clears the first integrator. During reset `sample` reads 0 and `sample_valid` reads 0, and bits at those edges are ignored.
- R8: Consider a step from an all-zero stream to an alternating 0/1 stream that begins just after a boundary of a phase. That phase's next sample still lies between the old and new levels. The sample after that equals N²/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the modulator bit is captured on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_bit | input | 1 | One-bit modulator output |
| len_sel | input | 3 | Decimation length code (R2) |
| ph_sel | input | 3 | Requested number of staggered phases (R3) |
| sample | output | 16 | Filtered sample, zero-extended, held between strobes |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
A sample closed at boundary edge e appears on `sample`/`sample_valid` immediately after that same edge, behind one output register. The bench therefore compares the strobe and the word at the falling edge after every rising edge, against a boundary schedule it derives from the last restart edge. A configuration change takes effect at the edge that first sees it: the following edge is count 0 of the new period. The warm-up window (at least 2N edges) is checked tick by tick rather than by sampling later. The step case reads the two phase-0 samples due exactly 3N and 4N edges after the restart edge.

// File: rtl/sinc2_pkg.sv
package sinc2_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned PH_W     = 3;
  localparam int unsigned MIN_LOG  = 4;
  localparam int unsigned MAX_CODE = 4;
  localparam int unsigned CNT_W    = MIN_LOG + MAX_CODE;
  localparam int unsigned ACC_W    = 2 * CNT_W;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [PH_W-1:0]   phases;
  } cfg_t;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
    return (32'(c) > MAX_CODE) ? CODE_W'(MAX_CODE) : c;
  endfunction

  function automatic int unsigned len_log(input logic [CODE_W-1:0] c);
    return MIN_LOG + 32'(clamp_code(c));
  endfunction

  function automatic int unsigned reg_width(input logic [CODE_W-1:0] c);
    return 2 * len_log(c);
  endfunction

  function automatic int unsigned max_phases(input logic [CODE_W-1:0] c,
                                             input int unsigned budget,
                                             input int unsigned ph_cap);
    int unsigned p;
    p = budget / reg_width(c);
    p = (p > 1) ? (p - 1) / 2 : 0;
    if (p > ph_cap) p = ph_cap;
    if (p < 1) p = 1;
    return p;
  endfunction
endpackage

// File: rtl/sinc2_cfg.sv
module sinc2_cfg
  import sinc2_pkg::*;
#(
  parameter int unsigned MAX_PH = 6,
  parameter int unsigned BUDGET = 112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] len_sel,
  input  logic [PH_W-1:0]   ph_sel,
  output logic              restart,
  output logic [CODE_W-1:0] code_q,
  output logic [PH_W-1:0]   nph_q
);
  cfg_t raw_q;
  cfg_t raw_in;
  logic [CODE_W-1:0] code_in;
  logic [PH_W-1:0]   nph_in;

  always_comb begin
    int unsigned pm;
    raw_in.code   = len_sel;
    raw_in.phases = ph_sel;
    code_in       = clamp_code(len_sel);
    pm            = max_phases(code_in, BUDGET, MAX_PH);
    if (ph_sel == '0)            nph_in = PH_W'(1);
    else if (32'(ph_sel) > pm)   nph_in = PH_W'(pm);
    else                         nph_in = ph_sel;
  end

  assign restart = !rst_n || (raw_q != raw_in);

  always_ff @(posedge clk) begin
    if (restart) begin
      raw_q  <= raw_in;
      code_q <= code_in;
      nph_q  <= nph_in;
    end
  end
endmodule

// File: rtl/sinc2_sched.sv
module sinc2_sched
  import sinc2_pkg::*;
#(
  parameter int unsigned MAX_PH = 6
) (
  input  logic              clk,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  input  logic [PH_W-1:0]   nph,
  output logic [MAX_PH-1:0] fire,
  output logic [MAX_PH-1:0] primed
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  int unsigned      n_len;
  int unsigned      divisor;

  always_comb begin
    n_len   = 32'd1 << len_log(code);
    last    = CNT_W'(n_len - 1);
    divisor = (nph == '0) ? 32'd1 : 32'(nph);
  end

  always_ff @(posedge clk) begin
    if (restart)          cnt <= '0;
    else if (cnt == last) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < MAX_PH; k++) begin : g_phase
    logic [CNT_W-1:0] close_at;
    logic [1:0]       seen;
    int unsigned      offset;

    always_comb begin
      offset   = (32'(k) * n_len) / divisor;
      close_at = (offset == 0) ? last : CNT_W'(offset - 1);
    end

    assign fire[k]   = (32'(k) < 32'(nph)) && (cnt == close_at);
    assign primed[k] = (seen == 2'd2);

    always_ff @(posedge clk) begin
      if (restart)                     seen <= 2'd0;
      else if (fire[k] && seen != 2'd2) seen <= seen + 2'd1;
    end
  end
endmodule

// File: rtl/sinc2_phase.sv
module sinc2_phase
  import sinc2_pkg::*;
(
  input  logic             clk,
  input  logic             restart,
  input  logic             fire,
  input  logic [ACC_W-1:0] acc1_next,
  output logic [ACC_W-1:0] result
);
  logic [ACC_W-1:0] acc2;
  logic [ACC_W-1:0] prev;
  logic [ACC_W-1:0] sum;

  assign sum    = acc2 + acc1_next;
  assign result = sum - prev;

  always_ff @(posedge clk) begin
    if (restart) begin
      acc2 <= '0;
      prev <= '0;
    end else if (fire) begin
      prev <= sum;
      acc2 <= '0;
    end else begin
      acc2 <= sum;
    end
  end
endmodule

// File: rtl/sinc2_stagger_dec.sv
module sinc2_stagger_dec
  import sinc2_pkg::*;
#(
  parameter int unsigned MAX_PH = 6,
  parameter int unsigned BUDGET = 112,
  parameter int unsigned OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_bit,
  input  logic [2:0]       len_sel,
  input  logic [2:0]       ph_sel,
  output logic [OUT_W-1:0] sample,
  output logic             sample_valid
);
  logic              restart;
  logic [CODE_W-1:0] code_q;
  logic [PH_W-1:0]   nph_q;
  logic [MAX_PH-1:0] fire;
  logic [MAX_PH-1:0] primed;
  logic [ACC_W-1:0]  acc1;
  logic [ACC_W-1:0]  acc1_next;
  logic [ACC_W-1:0]  res [MAX_PH];
  logic [ACC_W-1:0]  pick;
  logic [ACC_W-1:0]  mask;
  logic              emit;

  sinc2_cfg #(.MAX_PH(MAX_PH), .BUDGET(BUDGET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .ph_sel(ph_sel),
    .restart(restart), .code_q(code_q), .nph_q(nph_q)
  );

  sinc2_sched #(.MAX_PH(MAX_PH)) u_sched (
    .clk(clk), .restart(restart), .code(code_q), .nph(nph_q),
    .fire(fire), .primed(primed)
  );

  assign acc1_next = acc1 + ACC_W'(mod_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) acc1 <= '0;
    else        acc1 <= acc1_next;
  end

  for (genvar k = 0; k < MAX_PH; k++) begin : g_pair
    sinc2_phase u_pair (
      .clk(clk), .restart(restart), .fire(fire[k]),
      .acc1_next(acc1_next), .result(res[k])
    );
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < MAX_PH; k++) begin
      if (fire[k]) pick = res[k];
    end
    emit = |(fire & primed);
    mask = ACC_W'((32'd1 << reg_width(code_q)) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample       <= '0;
      sample_valid <= 1'b0;
    end else if (restart) begin
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= emit;
      if (emit) sample <= OUT_W'(pick & mask);
    end
  end
endmodule

// File: rtl/sinc2_stagger_dec_chk.sv
module sinc2_stagger_dec_chk
  import sinc2_pkg::*;
#(
  parameter int unsigned BUDGET = 112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [15:0]       sample,
  input logic              restart,
  input logic [CODE_W-1:0] code,
  input logic [PH_W-1:0]   nph
);
  logic [11:0] since;

  always_ff @(posedge clk) begin
    if (restart)              since <= '0;
    else if (since != 12'hfff) since <= since + 12'd1;
  end

  // R1: bits above the selected width stay zero
  assert_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((32'(sample) >> reg_width(code)) == 0));

  // R3: active storage within budget
  assert_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nph != '0) && (reg_width(code) * (1 + 2 * 32'(nph)) <= BUDGET));

  // R4: strobe never lasts two cycles
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R5: no sample before two full periods since restart
  assert_warmup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (32'(since) >= 2 * (32'd1 << len_log(code))));

  // R7: reset clears the output
  assert_reset_out_R7: assert property (@(posedge clk)
    !rst_n |=> (!valid && sample == '0));
endmodule

bind sinc2_stagger_dec sinc2_stagger_dec_chk #(.BUDGET(BUDGET)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(sample_valid), .sample(sample),
  .restart(restart), .code(code_q), .nph(nph_q)
);

// File: tb/sinc2_stagger_dec_bench.sv
module sinc2_stagger_dec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_bit = 1'b0;
  logic [2:0]  len_sel = 3'd0;
  logic [2:0]  ph_sel = 3'd6;
  logic [15:0] sample;
  logic        sample_valid;

  always #5 clk = ~clk;

  sinc2_stagger_dec u_sinc2_stagger_dec (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .len_sel(len_sel),
    .ph_sel(ph_sel), .sample(sample), .sample_valid(sample_valid)
  );

  localparam int HMAX = 20000;
  bit    hist [HMAX];
  int    e = 0, r = 0;
  int    checks = 0, errors = 0;
  int    n_len, wdt, np;
  int    offs [6];
  int    bcount [6];
  int    cur_code = 0, cur_ph = 6;
  bit    pending = 1'b0;
  bit    done = 1'b0;
  string val_tag = "R1", vld_tag = "R4";

  function automatic int b_len(int c);
    return (c > 4) ? 256 : (16 << c);
  endfunction
  function automatic int b_width(int c);
    return (c > 4) ? 16 : 8 + 2 * c;
  endfunction
  function automatic int b_phases(int c, int req);
    int pm;
    case ((c > 4) ? 4 : c)
      0: pm = 6;  1: pm = 5;  2: pm = 4;  default: pm = 3;
    endcase
    if (req < 1) return 1;
    return (req > pm) ? pm : req;
  endfunction

  function automatic longint tri_sum(int at, int n);
    longint s = 0;
    for (int m = 0; m <= 2 * n - 2; m++) begin
      int idx = at - m;
      int w = (m + 1 < 2 * n - 1 - m) ? m + 1 : 2 * n - 1 - m;
      if (idx >= 0 && hist[idx]) s += w;
    end
    return s;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", tag, what, e, act, exp);
    end
  endtask

  task automatic model_restart();
    n_len = b_len(cur_code);
    wdt   = b_width(cur_code);
    np    = b_phases(cur_code, cur_ph);
    for (int k = 0; k < 6; k++) begin
      offs[k]   = (k * n_len) / np;
      bcount[k] = 0;
    end
    r = e;
  endtask

  task automatic evaluate(bit in_rst);
    bit     exp_v = 1'b0;
    longint expv  = 0;
    if (in_rst) begin
      chk(sample_valid == 1'b0, "R7", "valid in reset", sample_valid, 0);
      chk(sample == 16'd0, "R7", "sample in reset", sample, 0);
      return;
    end
    if (e > r) begin
      int c = (e - r - 1) % n_len;
      for (int k = 0; k < np; k++) begin
        int endk = (offs[k] == 0) ? n_len - 1 : offs[k] - 1;
        if (c == endk) begin
          if (bcount[k] >= 2) begin
            exp_v = 1'b1;
            expv  = tri_sum(e, n_len) % (longint'(1) << wdt);
          end
          bcount[k]++;
        end
      end
    end
    if (exp_v || sample_valid) begin
      chk(sample_valid == exp_v, vld_tag, "valid strobe", sample_valid, exp_v);
      if (exp_v && sample_valid)
        chk(longint'(sample) == expv, val_tag, "sample value", sample, expv);
    end
  endtask

  task automatic tick(bit b);
    bit in_rst = !rst_n;
    mod_bit = b;
    @(posedge clk);
    e++;
    if (e < HMAX) hist[e] = in_rst ? 1'b0 : b;
    if (in_rst || pending) begin
      model_restart();
      pending = 1'b0;
    end
    @(negedge clk);
    evaluate(in_rst);
  endtask

  task automatic apply_cfg(int code, int ph, bit b);
    len_sel  = 3'(code);
    ph_sel   = 3'(ph);
    cur_code = code;
    cur_ph   = ph;
    pending  = 1'b1;
    tick(b);
  endtask

  task automatic run(int cycles, int dens);
    for (int i = 0; i < cycles; i++) tick(($urandom % 100) < dens);
  endtask

  initial begin
    void'($urandom(32'd9137));
    @(negedge clk);
    // R7: reset state
    repeat (4) tick(1'b1);
    rst_n = 1'b1;

    // R1 R4: smallest length, most phases
    val_tag = "R1"; vld_tag = "R4";
    run(220, 30);

    // R2 R5: every length code at its maximum phase count
    val_tag = "R2"; vld_tag = "R5";
    apply_cfg(1, 5, 1'b0); run(6 * 32 + 40, 60);
    apply_cfg(2, 4, 1'b1); run(6 * 64 + 40, 45);
    apply_cfg(3, 3, 1'b0); run(6 * 128 + 40, 20);
    apply_cfg(4, 3, 1'b1); run(6 * 256 + 40, 75);
    apply_cfg(6, 2, 1'b0); run(6 * 256 + 40, 50);

    // R3: clamping of the phase request
    val_tag = "R3"; vld_tag = "R3";
    apply_cfg(0, 7, 1'b1); run(220, 50);
    apply_cfg(2, 0, 1'b0); run(6 * 64 + 10, 40);
    apply_cfg(4, 6, 1'b0); run(6 * 256 + 10, 35);

    // R1: all-ones input wraps to zero
    val_tag = "R1"; vld_tag = "R4";
    apply_cfg(1, 2, 1'b1);
    for (int i = 0; i < 6 * 32; i++) tick(1'b1);

    // R6: configuration change mid-period
    val_tag = "R6"; vld_tag = "R6";
    apply_cfg(2, 4, 1'b0); run(150, 50);
    apply_cfg(0, 3, 1'b1); run(140, 50);

    // R8: step from zeros to alternating, single phase, N = 32
    val_tag = "R8"; vld_tag = "R8";
    apply_cfg(1, 1, 1'b0);
    for (int i = 1; i <= 4 * 32; i++) begin
      tick((i <= 64) ? 1'b0 : 1'(i % 2));
      if (i == 96) begin
        chk(sample_valid == 1'b1, "R8", "valid at 3N", sample_valid, 1);
        chk(sample != 16'd512, "R8", "not settled after one period", sample, 0);
      end
      if (i == 128) begin
        chk(sample_valid == 1'b1, "R8", "valid at 4N", sample_valid, 1);
        chk(sample == 16'd512, "R8", "settled value", sample, 512);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=200000 expected completion earlier");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule